// File: doc/BRIEF.md
# Idle Core Launch Controller

This block hands out processing cores in a system of eight cores. A launch request carries a 32-bit descriptor and an 18-bit parameter. The controller picks the idle core with the smallest index and marks it busy. It then reports the core index, or a failure flag when every core is already occupied. The same request also resets the chosen core and loads that core's two pointer registers.

The descriptor selects one of two start modes, using its top bit.

- **Top bit clear:** the core runs straight from shared memory. It starts at the address held in the descriptor.
- **Top bit set:** the descriptor holds a word count and a shared-memory source address. The controller passes these to an external loader as a copy job. The core starts at local address 0 once the loader reports that the copy is complete. A count of zero starts the core at once.

A per-core stop input returns that core to the idle pool.

Top module: `core_launch_ctrl`

## Requirements
- R1: A request grants the idle core with the smallest index (0..7); a core that is busy is never granted.
- R2: `rsp_valid` rises one cycle after `req_valid`. On success `rsp_fail`=0 and `rsp_core` holds the granted index. When all eight cores are busy, `rsp_fail`=1, no core is touched, and `rsp_core` carries no meaning.
- R3: The granted core's `core_ptra` is loaded with `req_param`, in the same cycle as the response.
- R4: The granted core's `core_ptrb` is loaded with `req_desc[17:0]` with its two low bits cleared (AND 0x3FFFC).
- R5: When descriptor bit 31 is 0:
  - the core's `core_hubexec` is set to 1;
  - its `core_pc` is set to `req_desc[17:0]`;
  - its `core_start` bit pulses in the response cycle;
  - no loader job is issued.
- R6: When descriptor bit 31 is 1, the descriptor is decoded as follows:
  - bits [20:12] are the word count;
  - bits [11:0] are the shared-memory source address;
  - bits [30:21] are ignored;
  - a nonzero count issues a one-cycle `ld_req` in the response cycle, carrying `ld_core`, `ld_count` and `ld_src`.
- R7: In copy mode the core's `core_pc` is set to 0 and `core_hubexec` is set to 0.
- R8: The granted core, and only that core, gets a one-cycle `core_reset` pulse in the response cycle.
- R9: A core is marked busy at the clock edge that grants it, so two requests in consecutive cycles receive different cores.
- R10: A one-cycle pulse on `core_stop[c]` makes core c idle from the next cycle on, and any copy still pending for it is dropped.
- R11: In copy mode with a nonzero count, `core_start[c]` stays low until `ld_done[c]` is seen. It then pulses for one cycle, in the cycle after `ld_done[c]`. A count of 0 starts the core in the response cycle. `ld_done` for a core with no pending copy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request strobe |
| req_desc | input | 32 | Launch descriptor |
| req_param | input | 18 | Parameter for the first pointer register |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_core | output | 3 | Granted core index |
| rsp_fail | output | 1 | 1 = no idle core |
| core_stop | input | 8 | Per-core stop pulse, returns the core to idle |
| core_reset | output | 8 | Per-core I/O reset pulse |
| core_start | output | 8 | Per-core start pulse |
| core_hubexec | output | 8 | Per-core start mode, 1 = run from shared memory |
| core_ptra | output | 8x18 | Per-core first pointer value |
| core_ptrb | output | 8x18 | Per-core second pointer value |
| core_pc | output | 8x18 | Per-core start address |
| ld_req | output | 1 | Copy job strobe to the loader |
| ld_core | output | 3 | Target core of the copy job |
| ld_src | output | 12 | Shared-memory source address of the job |
| ld_count | output | 9 | Number of words to copy |
| ld_done | input | 8 | Per-core copy-complete pulse from the loader |

## Verification
The following results appear exactly one clock after the edge that samples `req_valid`:

- the response fields;
- the reset pulse and pointer values;
- the start address;
- the loader strobe;
- for immediate starts, the start pulse.

A deferred start appears one clock after the edge that samples `ld_done`. The bench drives every input on the falling edge and samples on the following falling edge. Each check therefore sees the first registered result and nothing later. For copies it checks that `core_start` stays low in the cycles before `ld_done`, and that it falls again one cycle after its pulse.

// File: rtl/launch_pkg.sv
package launch_pkg;
   // Start mode carried by the descriptor's mode bit.
   typedef enum logic {
      START_SHARED = 1'b0,
      START_COPY   = 1'b1
   } start_mode_e;
endpackage

// File: rtl/launch_idle_pick.sv
module launch_idle_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     idle,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   if (N < 2 || (1 << IDX_W) < N) begin : g_bad_params
      $error("launch_idle_pick: index width too small for core count");
   end

   // Scan from the top so the lowest idle index is the last one kept.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (idle[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/launch_desc_decode.sv
module launch_desc_decode
   import launch_pkg::*;
#(
   parameter int DESC_W     = 32,
   parameter int ADDR_W     = 18,
   parameter int CNT_W      = 9,
   parameter int CNT_LSB    = 12,
   parameter int SRC_W      = 12,
   parameter int MODE_BIT   = 31,
   parameter int ALIGN_BITS = 2
) (
   input  logic [DESC_W-1:0] desc,
   output start_mode_e       mode,
   output logic [CNT_W-1:0]  count,
   output logic              count_zero,
   output logic [SRC_W-1:0]  src,
   output logic [ADDR_W-1:0] ptrb_addr,
   output logic [ADDR_W-1:0] start_pc
);
   if (CNT_LSB + CNT_W > MODE_BIT || SRC_W > CNT_LSB || ADDR_W > MODE_BIT ||
       MODE_BIT >= DESC_W || ALIGN_BITS < 1 || ALIGN_BITS >= ADDR_W) begin : g_bad_layout
      $error("launch_desc_decode: descriptor fields overlap or exceed width");
   end

   // Bits between the count field and the mode bit are reserved / ignored.
   logic unused_reserved;
   assign unused_reserved = ^desc[MODE_BIT-1:CNT_LSB+CNT_W];

   assign mode       = start_mode_e'(desc[MODE_BIT]);
   assign count      = desc[CNT_LSB +: CNT_W];
   assign count_zero = (count == '0);
   assign src        = desc[SRC_W-1:0];
   assign ptrb_addr  = {desc[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   assign start_pc   = (mode == START_COPY) ? '0 : desc[ADDR_W-1:0];
endmodule

// File: rtl/launch_core_slot.sv
module launch_core_slot #(
   parameter int PARAM_W = 18,
   parameter int ADDR_W  = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               grant,
   input  logic               stop,
   input  logic               ld_done,
   input  logic               copy_mode,
   input  logic               count_zero,
   input  logic [PARAM_W-1:0] ptra_in,
   input  logic [ADDR_W-1:0]  ptrb_in,
   input  logic [ADDR_W-1:0]  pc_in,
   output logic               busy,
   output logic               reset_o,
   output logic               start_o,
   output logic               hubexec_o,
   output logic [PARAM_W-1:0] ptra_o,
   output logic [ADDR_W-1:0]  ptrb_o,
   output logic [ADDR_W-1:0]  pc_o
);
   logic pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pending   <= 1'b0;
         reset_o   <= 1'b0;
         start_o   <= 1'b0;
         hubexec_o <= 1'b0;
         ptra_o    <= '0;
         ptrb_o    <= '0;
         pc_o      <= '0;
      end else begin
         reset_o <= grant;
         start_o <= 1'b0;
         if (grant) begin
            busy      <= 1'b1;
            ptra_o    <= ptra_in;
            ptrb_o    <= ptrb_in;
            pc_o      <= pc_in;
            hubexec_o <= !copy_mode;
            pending   <= copy_mode && !count_zero;
            start_o   <= !copy_mode || count_zero;
         end else if (stop) begin
            busy    <= 1'b0;
            pending <= 1'b0;
         end else if (pending && ld_done) begin
            pending <= 1'b0;
            start_o <= 1'b1;
         end
      end
   end

   AST_GRANT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> !busy); // R9
   AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> busy); // R9
   AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !grant) |=> !busy); // R10
   AST_COPY_WAITS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && !hubexec_o && !$past(grant)) |-> $past(ld_done)); // R11
   AST_RESET_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      reset_o |-> busy); // R8
endmodule

// File: rtl/core_launch_ctrl.sv
module core_launch_ctrl
   import launch_pkg::*;
#(
   parameter int N_CORES    = 8,
   parameter int DESC_W     = 32,
   parameter int PARAM_W    = 18,
   parameter int ADDR_W     = 18,
   parameter int CNT_W      = 9,
   parameter int CNT_LSB    = 12,
   parameter int SRC_W      = 12,
   parameter int MODE_BIT   = 31,
   parameter int ALIGN_BITS = 2,
   localparam int IDX_W     = $clog2(N_CORES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   input  logic [DESC_W-1:0]                 req_desc,
   input  logic [PARAM_W-1:0]                req_param,
   output logic                              rsp_valid,
   output logic [IDX_W-1:0]                  rsp_core,
   output logic                              rsp_fail,
   input  logic [N_CORES-1:0]                core_stop,
   output logic [N_CORES-1:0]                core_reset,
   output logic [N_CORES-1:0]                core_start,
   output logic [N_CORES-1:0]                core_hubexec,
   output logic [N_CORES-1:0][PARAM_W-1:0]   core_ptra,
   output logic [N_CORES-1:0][ADDR_W-1:0]    core_ptrb,
   output logic [N_CORES-1:0][ADDR_W-1:0]    core_pc,
   output logic                              ld_req,
   output logic [IDX_W-1:0]                  ld_core,
   output logic [SRC_W-1:0]                  ld_src,
   output logic [CNT_W-1:0]                  ld_count,
   input  logic [N_CORES-1:0]                ld_done
);
   logic [N_CORES-1:0] busy;
   logic [N_CORES-1:0] grant_vec;
   logic               pick_found;
   logic [IDX_W-1:0]   pick_idx;
   start_mode_e        dec_mode;
   logic [CNT_W-1:0]   dec_count;
   logic               dec_count_zero;
   logic [SRC_W-1:0]   dec_src;
   logic [ADDR_W-1:0]  dec_ptrb;
   logic [ADDR_W-1:0]  dec_pc;
   logic               grant_ok;
   logic               copy_mode;

   launch_idle_pick #(.N(N_CORES), .IDX_W(IDX_W)) u_pick (
      .idle  (~busy),
      .found (pick_found),
      .idx   (pick_idx)
   );

   launch_desc_decode #(
      .DESC_W(DESC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB),
      .SRC_W(SRC_W), .MODE_BIT(MODE_BIT), .ALIGN_BITS(ALIGN_BITS)
   ) u_dec (
      .desc       (req_desc),
      .mode       (dec_mode),
      .count      (dec_count),
      .count_zero (dec_count_zero),
      .src        (dec_src),
      .ptrb_addr  (dec_ptrb),
      .start_pc   (dec_pc)
   );

   assign grant_ok  = req_valid && pick_found;
   assign copy_mode = (dec_mode == START_COPY);
   assign grant_vec = grant_ok ? (N_CORES'(1) << pick_idx) : '0;

   for (genvar c = 0; c < N_CORES; c++) begin : g_slot
      launch_core_slot #(.PARAM_W(PARAM_W), .ADDR_W(ADDR_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .grant      (grant_vec[c]),
         .stop       (core_stop[c]),
         .ld_done    (ld_done[c]),
         .copy_mode  (copy_mode),
         .count_zero (dec_count_zero),
         .ptra_in    (req_param),
         .ptrb_in    (dec_ptrb),
         .pc_in      (dec_pc),
         .busy       (busy[c]),
         .reset_o    (core_reset[c]),
         .start_o    (core_start[c]),
         .hubexec_o  (core_hubexec[c]),
         .ptra_o     (core_ptra[c]),
         .ptrb_o     (core_ptrb[c]),
         .pc_o       (core_pc[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_core  <= '0;
         rsp_fail  <= 1'b0;
         ld_req    <= 1'b0;
         ld_core   <= '0;
         ld_src    <= '0;
         ld_count  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_fail  <= req_valid && !pick_found;
         rsp_core  <= pick_found ? pick_idx : '0;
         ld_req    <= grant_ok && copy_mode && !dec_count_zero;
         if (grant_ok) begin
            ld_core  <= pick_idx;
            ld_src   <= dec_src;
            ld_count <= dec_count;
         end
      end
   end

   // R1: every core below the picked index is busy, the picked one is idle.
   always_comb begin
      if (rst_n && grant_ok) begin
         AST_PICK_IS_IDLE: assert (!busy[pick_idx]); // R1
         for (int j = 0; j < N_CORES; j++) begin
            if (j < int'(pick_idx)) begin
               AST_LOWEST_IDLE: assert (busy[j]); // R1
            end
         end
      end
   end

   AST_FAIL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_valid && (rsp_fail == $past(&busy)))); // R2
   AST_LOADER_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |-> !core_start[ld_core]); // R11
endmodule

// File: tb/core_launch_ctrl_tb_top.sv
`timescale 1ns/1ps
module core_launch_ctrl_tb_top;
   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic [31:0]       req_desc;
   logic [17:0]       req_param;
   logic              rsp_valid;
   logic [2:0]        rsp_core;
   logic              rsp_fail;
   logic [7:0]        core_stop;
   logic [7:0]        core_reset;
   logic [7:0]        core_start;
   logic [7:0]        core_hubexec;
   logic [7:0][17:0]  core_ptra;
   logic [7:0][17:0]  core_ptrb;
   logic [7:0][17:0]  core_pc;
   logic              ld_req;
   logic [2:0]        ld_core;
   logic [11:0]       ld_src;
   logic [8:0]        ld_count;
   logic [7:0]        ld_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   core_launch_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_desc(req_desc),
      .req_param(req_param), .rsp_valid(rsp_valid), .rsp_core(rsp_core),
      .rsp_fail(rsp_fail), .core_stop(core_stop), .core_reset(core_reset),
      .core_start(core_start), .core_hubexec(core_hubexec), .core_ptra(core_ptra),
      .core_ptrb(core_ptrb), .core_pc(core_pc), .ld_req(ld_req), .ld_core(ld_core),
      .ld_src(ld_src), .ld_count(ld_count), .ld_done(ld_done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drive a request for one cycle; returns at the falling edge after the
   // capturing rising edge, where registered results are visible.
   task automatic send(input logic [31:0] d, input logic [17:0] p);
      req_valid = 1'b1;
      req_desc  = d;
      req_param = p;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic stop_cores(input logic [7:0] m);
      core_stop = m;
      @(negedge clk);
      core_stop = '0;
   endtask

   task automatic t_reset();
      chk("R2 rsp_valid after reset", rsp_valid, 0);
      chk("R8 core_reset after reset", core_reset, 0);
      chk("R11 core_start after reset", core_start, 0);
      chk("R6 ld_req after reset", ld_req, 0);
   endtask

   task automatic t_shared_exec();
      send(32'h0001_2346, 18'h2ABCD);
      chk("R2 rsp_valid", rsp_valid, 1);
      chk("R2 rsp_fail", rsp_fail, 0);
      chk("R1 first grant core0", rsp_core, 0);
      chk("R8 reset only core0", core_reset, 8'h01);
      chk("R5 start core0 at once", core_start, 8'h01);
      chk("R5 hubexec core0", core_hubexec[0], 1);
      chk("R5 pc core0", core_pc[0], 18'h12346);
      chk("R5 no loader job", ld_req, 0);
      chk("R3 ptra core0", core_ptra[0], 18'h2ABCD);
      chk("R4 ptrb core0 aligned", core_ptrb[0], 18'h12344);
      @(negedge clk);
      chk("R5 start is a pulse", core_start, 0);
   endtask

   task automatic t_copy();
      // mode=1, bits 30:21 all ones (ignored), count=5, src=0xABC
      send(32'hFFE0_5ABC, 18'h00011);
      chk("R1 second grant core1", rsp_core, 1);
      chk("R6 ld_req", ld_req, 1);
      chk("R6 ld_core", ld_core, 1);
      chk("R6 ld_count", ld_count, 5);
      chk("R6 ld_src", ld_src, 12'hABC);
      chk("R11 no start before done", core_start, 0);
      chk("R7 pc core1 zero", core_pc[1], 0);
      chk("R7 hubexec core1 clear", core_hubexec[1], 0);
      chk("R4 ptrb core1", core_ptrb[1], 18'h05ABC);
      chk("R3 ptra core1", core_ptra[1], 18'h00011);
      @(negedge clk);
      chk("R6 ld_req one cycle", ld_req, 0);
      ld_done = 8'h01; // core0 has no pending copy: ignored
      @(negedge clk);
      ld_done = '0;
      chk("R11 stray done ignored", core_start, 0);
      @(negedge clk);
      chk("R11 still waiting", core_start, 0);
      ld_done = 8'h02;
      @(negedge clk);
      ld_done = '0;
      chk("R11 start after done", core_start, 8'h02);
      @(negedge clk);
      chk("R11 start pulse ends", core_start, 0);
   endtask

   task automatic t_count_zero();
      send(32'h8000_0123, 18'h0);
      chk("R1 third grant core2", rsp_core, 2);
      chk("R11 count zero starts at once", core_start, 8'h04);
      chk("R11 count zero no loader job", ld_req, 0);
      chk("R7 pc core2 zero", core_pc[2], 0);
      chk("R4 ptrb core2", core_ptrb[2], 18'h00120);
   endtask

   task automatic t_fill_and_fail();
      for (int k = 3; k < 8; k++) begin
         send(32'h0000_0400, 18'(k));
         chk("R1 fill grant", rsp_core, k);
         chk("R2 fill ok", rsp_fail, 0);
      end
      send(32'h0000_0800, 18'h1);
      chk("R2 all busy fails", rsp_fail, 1);
      chk("R2 fail rsp_valid", rsp_valid, 1);
      chk("R8 no reset on fail", core_reset, 0);
      chk("R2 no start on fail", core_start, 0);
      chk("R3 ptra core3 untouched", core_ptra[3], 3);
   endtask

   task automatic t_stop_reuse();
      stop_cores(8'h50); // cores 4 and 6
      send(32'h0000_1000, 18'h3);
      chk("R10 stopped core4 reused", rsp_core, 4);
      chk("R10 grant ok", rsp_fail, 0);
      chk("R8 reset core4", core_reset, 8'h10);
   endtask

   task automatic t_back_to_back();
      stop_cores(8'h04); // core 2; core 6 is still idle
      send(32'h0000_2000, 18'h7);
      chk("R9 b2b first core2", rsp_core, 2);
      send(32'h0000_3000, 18'h8);
      chk("R9 b2b second core6", rsp_core, 6);
      chk("R9 b2b second ok", rsp_fail, 0);
      chk("R8 reset core6 only", core_reset, 8'h40);
      chk("R3 ptra core6", core_ptra[6], 18'h8);
      send(32'h0000_3000, 18'h9);
      chk("R9 third request fails", rsp_fail, 1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_desc = '0; req_param = '0;
      core_stop = '0; ld_done = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shared_exec();
      t_copy();
      t_count_zero();
      t_fill_and_fail();
      t_stop_reuse();
      t_back_to_back();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule